// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a 45-bit physical address by reading a three-level radix page table from memory. A requester hands over one virtual address with a valid/ready handshake. The walker then reads one 64-bit page table entry per level, in order from the top level to the leaf. Each entry it reads gives the frame that holds the next table. The leaf entry gives the data frame.

Pages are 8 KB. Bits 12:0 of the virtual address are the page offset. Three 10-bit indices sit above the offset: bits 42:33 select the entry in the top table, bits 32:23 in the middle table and bits 22:13 in the leaf table. Bits 63:43 play no part in the walk.

Each entry is 8 bytes. Bit 0 is the valid flag and bits 63:32 hold a 32-bit frame number. Any entry whose valid flag is clear ends the walk with a fault. The single result port carries everything a TLB refill needs: the virtual page number, the physical address, a fault flag and the level at which the walk stopped.

Top module: `page_walker`

## Requirements
- R1: Out of reset, req_ready is 1, res_valid is 0, mem_req_valid is 0 and the table root register holds 0.
- R2: The first memory read of a walk is at root + 8 × va[42:33], computed as a full 45-bit sum that wraps modulo 2^45. The root used is the register value in the cycle the request is accepted.
- R3: When a walk meets no fault, it makes exactly three reads and makes them strictly in order. The second read is at (pte1[63:32] × 2^13) + 8 × va[32:23], and the third is at (pte2[63:32] × 2^13) + 8 × va[22:13]. Each read is issued only after the response to the previous one.
- R4: After a walk with no fault, res_valid is 1 for exactly one cycle with res_fault = 0, res_level = 3, res_paddr = {pte3[63:32], va[12:0]} and res_vpn = va[42:13].
- R5: A response whose bit 0 is 0 ends the walk at once, and no further read is issued. res_valid is then 1 for one cycle with res_fault = 1, res_level set to the level that faulted (1, 2 or 3), res_paddr = 0 and res_vpn = va[42:13].
- R6: Only one walk runs at a time. req_ready falls in the cycle after acceptance and stays 0 until the cycle in which res_valid is 1, when it is 1 again. Requests presented during a walk are dropped.
- R7: The response may arrive any number of cycles (one or more) after the read. mem_rsp_valid is ignored whenever no read is outstanding.
- R8: A root write while idle is used by the next walk that is accepted later. A root write in the same cycle as an acceptance does not affect that walk, but it does affect the following one.
- R9: A root write while a walk is in progress is ignored.
- R10: mem_req_valid is high for a single cycle per read. The first read is requested in the cycle after acceptance, and each later read in the cycle after the previous response.
- R11: Bits 63:43 of the virtual address and bits 31:1 of every entry have no effect on any read address or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_we | input | 1 | Write strobe for the table root register |
| base_wdata | input | 45 | New table root address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 64 | Virtual address to translate |
| mem_req_valid | output | 1 | Single-cycle read request |
| mem_req_addr | output | 45 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Entry returned by memory |
| res_valid | output | 1 | Result present for one cycle |
| res_fault | output | 1 | Walk ended on an entry that is not valid |
| res_level | output | 2 | Level of the last entry read (1 to 3) |
| res_paddr | output | 45 | Translated physical address, 0 on a fault |
| res_vpn | output | 30 | Virtual page number of the translated request |

## Verification
The bench tries the walker with the following input patterns:
- Indices at the edges of their range (all zeros, all ones, alternating) with offsets at both ends. These show whether each 10-bit field is taken from the right bit position and scaled by eight.
- A root near the top of the address space. This shows whether the full-width add wraps correctly.
- A fault at each of the three levels. This separates a clean stop at the right level from a walk that reads one entry too many or one too few.
- Response latencies from one to twenty cycles, stray responses while idle, and root writes and extra requests during a walk. These show that only an outstanding read moves the walk forward and that mid-walk traffic leaves no mark.
- A pseudo-random sweep with random garbage in the upper virtual bits and in the ignored entry bits. This covers the remaining combinations.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned VA_W      = 64;
  localparam int unsigned PA_W      = 45;
  localparam int unsigned OFF_W     = 13;
  localparam int unsigned IDX_W     = 10;
  localparam int unsigned LEVELS    = 3;
  localparam int unsigned PTE_W     = 64;
  localparam int unsigned PFN_W     = 32;
  localparam int unsigned PFN_LSB   = 32;
  localparam int unsigned PTE_SHIFT = 3;
  localparam int unsigned VPN_W     = IDX_W * LEVELS;
  localparam int unsigned VA_USED   = OFF_W + VPN_W;
  localparam int unsigned LVL_W     = $clog2(LEVELS + 1);

  typedef logic [PA_W-1:0]  paddr_t;
  typedef logic [PFN_W-1:0] pfn_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {WS_IDLE, WS_ISSUE, WS_WAIT} walk_state_e;

  // Byte address of one entry inside a table that starts at tbl.
  function automatic paddr_t entry_addr(paddr_t tbl, idx_t idx);
    return tbl + (paddr_t'(idx) << PTE_SHIFT);
  endfunction

  // Start address of the table held in a frame.
  function automatic paddr_t frame_base(pfn_t pfn);
    return paddr_t'({pfn, {OFF_W{1'b0}}});
  endfunction

  // Final physical address: frame number followed by the page offset.
  function automatic paddr_t frame_join(pfn_t pfn, logic [OFF_W-1:0] off);
    return paddr_t'({pfn, off});
  endfunction
endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split
  import ptw_pkg::*;
(
  input  logic [VA_USED-1:0]            va,
  output logic [LEVELS-1:0][IDX_W-1:0]  idx,
  output logic [OFF_W-1:0]              off,
  output logic [VPN_W-1:0]              vpn
);
  // idx[0] selects in the top table, idx[LEVELS-1] in the leaf table.
  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    assign idx[l] = va[OFF_W + IDX_W*(LEVELS-1-l) +: IDX_W];
  end

  assign off = va[OFF_W-1:0];
  assign vpn = va[VA_USED-1:OFF_W];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  paddr_t                       tbl,
  input  lvl_t                         level,
  input  logic [LEVELS-1:0][IDX_W-1:0] idx,
  output paddr_t                       addr
);
  idx_t sel;

  always_comb begin
    sel = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (level == lvl_t'(l + 1)) sel = idx[l];
    end
  end

  assign addr = entry_addr(tbl, sel);
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte,
  output logic             valid,
  output pfn_t             pfn,
  output paddr_t           next_tbl
);
  logic unused_pte_bits;

  assign valid           = pte[0];
  assign pfn             = pte[PFN_LSB +: PFN_W];
  assign next_tbl        = frame_base(pfn);
  assign unused_pte_bits = ^pte[PFN_LSB-1:1];
endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [PA_W-1:0]   base_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              res_valid,
  output logic              res_fault,
  output logic [LVL_W-1:0]  res_level,
  output logic [PA_W-1:0]   res_paddr,
  output logic [VPN_W-1:0]  res_vpn
);
  walk_state_e          state_q;
  paddr_t               base_q;
  paddr_t               tbl_q;
  lvl_t                 level_q;
  logic [VA_USED-1:0]   va_q;

  logic                 res_valid_q, res_fault_q;
  lvl_t                 res_level_q;
  paddr_t               res_paddr_q;
  logic [VPN_W-1:0]     res_vpn_q;

  logic [LEVELS-1:0][IDX_W-1:0] va_idx;
  logic [OFF_W-1:0]     va_off;
  logic [VPN_W-1:0]     va_vpn;
  paddr_t               pte_addr;
  logic                 pte_valid;
  pfn_t                 pte_pfn;
  paddr_t               next_tbl;
  logic                 unused_va_hi;

  // Internal events, named for the assertions.
  logic accept, rsp_take, walk_fault, walk_done, step_next, base_take;

  assign unused_va_hi = ^req_vaddr[VA_W-1:VA_USED];

  ptw_va_split u_split (
    .va  (va_q),
    .idx (va_idx),
    .off (va_off),
    .vpn (va_vpn)
  );

  ptw_addr_gen u_addr (
    .tbl   (tbl_q),
    .level (level_q),
    .idx   (va_idx),
    .addr  (pte_addr)
  );

  ptw_pte_decode u_dec (
    .pte      (mem_rsp_data),
    .valid    (pte_valid),
    .pfn      (pte_pfn),
    .next_tbl (next_tbl)
  );

  assign req_ready  = (state_q == WS_IDLE);
  assign accept     = req_valid && req_ready;
  assign base_take  = base_we && (state_q == WS_IDLE);
  assign rsp_take   = mem_rsp_valid && (state_q == WS_WAIT);
  assign walk_fault = rsp_take && !pte_valid;
  assign walk_done  = rsp_take && pte_valid && (level_q == lvl_t'(LEVELS));
  assign step_next  = rsp_take && pte_valid && (level_q != lvl_t'(LEVELS));

  assign mem_req_valid = (state_q == WS_ISSUE);
  assign mem_req_addr  = pte_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= WS_IDLE;
      base_q      <= '0;
      tbl_q       <= '0;
      level_q     <= '0;
      va_q        <= '0;
      res_valid_q <= 1'b0;
      res_fault_q <= 1'b0;
      res_level_q <= '0;
      res_paddr_q <= '0;
      res_vpn_q   <= '0;
    end else begin
      res_valid_q <= 1'b0;
      if (base_take) base_q <= base_wdata;
      unique case (state_q)
        WS_IDLE: begin
          if (accept) begin
            va_q    <= req_vaddr[VA_USED-1:0];
            tbl_q   <= base_q;
            level_q <= lvl_t'(1);
            state_q <= WS_ISSUE;
          end
        end
        WS_ISSUE: state_q <= WS_WAIT;
        WS_WAIT: begin
          if (step_next) begin
            tbl_q   <= next_tbl;
            level_q <= level_q + lvl_t'(1);
            state_q <= WS_ISSUE;
          end else if (walk_fault || walk_done) begin
            state_q     <= WS_IDLE;
            res_valid_q <= 1'b1;
            res_fault_q <= walk_fault;
            res_level_q <= level_q;
            res_paddr_q <= walk_done ? frame_join(pte_pfn, va_off) : '0;
            res_vpn_q   <= va_vpn;
          end
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign res_valid = res_valid_q;
  assign res_fault = res_fault_q;
  assign res_level = res_level_q;
  assign res_paddr = res_paddr_q;
  assign res_vpn   = res_vpn_q;

  // Reads issued since the last acceptance, kept for the bound check.
  logic [LVL_W:0] rd_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rd_cnt_q <= '0;
    else if (accept)        rd_cnt_q <= '0;
    else if (mem_req_valid) rd_cnt_q <= rd_cnt_q + 1'b1;
  end

  p_reads_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt_q <= (LVL_W+1)'(LEVELS));

  p_next_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_next |=> mem_req_valid);

  p_done_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> (res_valid && !res_fault && res_level == lvl_t'(LEVELS)));

  p_res_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_fault_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    walk_fault |=> (res_valid && res_fault && req_ready && !mem_req_valid));

  p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!req_ready && mem_req_valid));

  p_ignore_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && state_q != WS_WAIT) |=> !res_valid);

  p_base_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(base_q));

  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
endmodule

// File: tb/tb_page_walker.sv
`timescale 1ns/1ps
module tb_page_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [44:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic        mem_req_valid;
  logic [44:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        res_valid, res_fault;
  logic [1:0]  res_level;
  logic [44:0] res_paddr;
  logic [29:0] res_vpn;

  always #2 clk = ~clk;

  page_walker dut (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_fault(res_fault), .res_level(res_level),
    .res_paddr(res_paddr), .res_vpn(res_vpn)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  int          cycles = 0;
  logic [44:0] model_base = '0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R7 actual=%0d expected=below 150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [63:0] xs(input logic [63:0] s);
    logic [63:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  // Entry: frame number, junk in 31:1, valid flag in bit 0.
  function automatic logic [63:0] mk_pte(input logic [31:0] pfn, input logic v, input logic [30:0] junk);
    return {pfn, junk, v};
  endfunction

  task automatic write_base(input logic [44:0] v);
    @(negedge clk);
    base_we = 1'b1;
    base_wdata = v;
    @(negedge clk);
    base_we = 1'b0;
    model_base = v;
  endtask

  task automatic run_walk(input logic [63:0] va, input logic [63:0] p1, input logic [63:0] p2,
                          input logic [63:0] p3, input int lat, input bit poke,
                          input bit wr_acc, input logic [44:0] wv);
    logic [63:0] pt [3];
    logic [44:0] exp_a [3];
    logic [44:0] seen_a [3];
    int          exp_n, nreq, pend;
    bit          got, ready_bad, pulse_bad, time_bad, expect_req, prev_req, rsp_now, flt;
    logic        r_fault;
    logic [1:0]  r_lvl;
    logic [44:0] r_pa;
    logic [29:0] r_vpn;
    pt[0] = p1; pt[1] = p2; pt[2] = p3;
    exp_n = 3;
    if (!p1[0]) exp_n = 1;
    else if (!p2[0]) exp_n = 2;
    flt = !pt[exp_n-1][0];
    exp_a[0] = model_base + {32'd0, va[42:33], 3'b000};
    exp_a[1] = {p1[63:32], 13'd0} + {32'd0, va[32:23], 3'b000};
    exp_a[2] = {p2[63:32], 13'd0} + {32'd0, va[22:13], 3'b000};
    seen_a[0] = '0; seen_a[1] = '0; seen_a[2] = '0;

    @(negedge clk);
    chk("R6 ready while idle", req_ready, 1);
    req_valid = 1'b1;
    req_vaddr = va;
    if (wr_acc) begin
      base_we = 1'b1;
      base_wdata = wv;
    end
    @(negedge clk);
    req_valid = 1'b0;
    base_we = 1'b0;
    if (wr_acc) model_base = wv;

    nreq = 0; pend = -1; got = 0; expect_req = 1; prev_req = 0;
    ready_bad = 0; pulse_bad = 0; time_bad = 0;
    r_fault = 0; r_lvl = 0; r_pa = 0; r_vpn = 0;
    for (int cyc = 0; cyc < 400 && !got; cyc++) begin
      rsp_now = 0;
      mem_rsp_valid = 1'b0;
      base_we = 1'b0;
      req_valid = 1'b0;
      if (res_valid) begin
        got = 1;
        r_fault = res_fault; r_lvl = res_level; r_pa = res_paddr; r_vpn = res_vpn;
        chk("R6 ready back with result", req_ready, 1);
      end else begin
        if (req_ready) ready_bad = 1;
        if (pend > 0) begin
          pend--;
          if (pend == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data = (nreq >= 1 && nreq <= 3) ? pt[nreq-1] : 64'd0;
            pend = -1;
            rsp_now = 1;
          end
        end
        if (mem_req_valid) begin
          if (prev_req) pulse_bad = 1;
          if (!expect_req) time_bad = 1;
          if (nreq < 3) seen_a[nreq] = mem_req_addr;
          nreq++;
          pend = lat;
        end
        expect_req = rsp_now && mem_rsp_data[0] && (nreq < 3);
        prev_req = mem_req_valid;
        if (poke && cyc == 1) begin
          base_we = 1'b1;
          base_wdata = ~model_base;
          req_valid = 1'b1;
          req_vaddr = ~va;
        end
        @(negedge clk);
      end
    end
    mem_rsp_valid = 1'b0;
    base_we = 1'b0;
    req_valid = 1'b0;

    chk("R7 walk completes", got, 1);
    chk(flt ? "R5 reads stop at fault" : "R3 three reads", nreq, exp_n);
    for (int k = 0; k < 3; k++) begin
      if (k < exp_n && k < nreq)
        chk(k == 0 ? "R2 first read address" : "R3 next-level read address", seen_a[k], exp_a[k]);
    end
    chk("R6 ready low during walk", ready_bad, 0);
    chk("R10 single-cycle read request", pulse_bad, 0);
    chk("R10 read request timing", time_bad, 0);
    chk(flt ? "R5 fault flag" : "R4 fault flag", r_fault, flt);
    chk(flt ? "R5 fault level" : "R4 level", r_lvl, exp_n);
    chk(flt ? "R5 paddr zero" : "R4 paddr", r_pa, flt ? 45'd0 : {p3[63:32], va[12:0]});
    chk("R4 vpn", r_vpn, va[42:13]);
    @(negedge clk);
    chk("R4 result pulse", res_valid, 0);
    chk("R6 dropped request starts nothing", {req_ready, mem_req_valid}, 2'b10);
    req_vaddr = '0;
  endtask

  initial begin
    logic [63:0] va, p1, p2, p3;
    int          fl;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", req_ready, 1);
    chk("R1 no result in reset", res_valid, 0);
    chk("R1 no read in reset", mem_req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);

    // R1: root starts at zero.
    run_walk(64'h0000_0401_0080_4ABC, mk_pte(32'h0000_1111, 1, 31'h5A5A_5A5A),
             mk_pte(32'h0000_2222, 1, 31'h1234_5678), mk_pte(32'hCAFE_0001, 1, 31'h7FFF_FFFF),
             1, 0, 0, '0);

    // R8: root written while idle.
    write_base(45'h1234_5678_9AB8);
    run_walk(64'h0, mk_pte(32'h1, 1, 31'h0), mk_pte(32'h2, 1, 31'h0), mk_pte(32'h3, 1, 31'h0), 2, 0, 0, '0);
    run_walk(64'h0000_07FF_FFFF_FFFF, mk_pte(32'hFFFF_FFFF, 1, 31'h0), mk_pte(32'hFFFF_FFFE, 1, 31'h0),
             mk_pte(32'hFFFF_FFFF, 1, 31'h0), 1, 0, 0, '0);
    run_walk(64'h0000_0555_5555_5555, mk_pte(32'hAAAA_AAAA, 1, 31'h2AAA_AAAA), mk_pte(32'h5555_5555, 1, 31'h0),
             mk_pte(32'h0F0F_0F0F, 1, 31'h0), 3, 0, 0, '0);
    // R11: upper bits garbage, same low bits give the same walk.
    run_walk(64'hFFFF_FD55_5555_5555, mk_pte(32'hAAAA_AAAA, 1, 31'h0), mk_pte(32'h5555_5555, 1, 31'h3),
             mk_pte(32'h0F0F_0F0F, 1, 31'h7FFF_FFFF), 3, 0, 0, '0);

    // R2: root near the top, the sum wraps.
    write_base(45'h1FFF_FFFF_FFF8);
    run_walk(64'h0000_0002_0000_0000, mk_pte(32'h10, 1, 31'h0), mk_pte(32'h20, 1, 31'h0),
             mk_pte(32'h30, 1, 31'h0), 1, 0, 0, '0);

    // R5: fault at each level.
    write_base(45'h0000_4000_0000);
    run_walk(64'h0000_0123_4567_89AB, mk_pte(32'h100, 0, 31'h7FFF_FFFF), mk_pte(32'h200, 1, 31'h0),
             mk_pte(32'h300, 1, 31'h0), 1, 0, 0, '0);
    run_walk(64'h0000_0123_4567_89AB, mk_pte(32'h100, 1, 31'h0), mk_pte(32'h200, 0, 31'h0),
             mk_pte(32'h300, 1, 31'h0), 2, 0, 0, '0);
    run_walk(64'h0000_0123_4567_89AB, mk_pte(32'h100, 1, 31'h0), mk_pte(32'h200, 1, 31'h0),
             mk_pte(32'h300, 0, 31'h0), 4, 0, 0, '0);

    // R7: long latency.
    run_walk(64'h0000_0600_0300_1FFF, mk_pte(32'h77, 1, 31'h0), mk_pte(32'h88, 1, 31'h0),
             mk_pte(32'h99, 1, 31'h0), 20, 0, 0, '0);

    // R9 and R6: root write and request during a walk, then a walk on the old root.
    run_walk(64'h0000_0100_0200_0400, mk_pte(32'h5, 1, 31'h0), mk_pte(32'h6, 1, 31'h0),
             mk_pte(32'h7, 1, 31'h0), 3, 1, 0, '0);
    run_walk(64'h0000_0000_0000_2000, mk_pte(32'h5, 1, 31'h0), mk_pte(32'h6, 1, 31'h0),
             mk_pte(32'h7, 1, 31'h0), 1, 0, 0, '0);

    // R8: root write in the acceptance cycle applies only to the next walk.
    run_walk(64'h0000_03FF_0000_0000, mk_pte(32'h42, 1, 31'h0), mk_pte(32'h43, 1, 31'h0),
             mk_pte(32'h44, 1, 31'h0), 1, 0, 1, 45'h0ABC_DE00_0000);
    run_walk(64'h0000_03FF_0000_0000, mk_pte(32'h42, 1, 31'h0), mk_pte(32'h43, 1, 31'h0),
             mk_pte(32'h44, 1, 31'h0), 1, 0, 0, '0);

    // R7: stray response while idle.
    @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data = mk_pte(32'h1, 1, 31'h0);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R7 stray response gives no result", res_valid, 0);
    chk("R7 stray response gives no read", mem_req_valid, 0);
    @(negedge clk);
    chk("R7 still idle after stray response", {req_ready, res_valid}, 2'b10);

    // Sweep.
    for (int i = 0; i < 80; i++) begin
      if (i % 10 == 0) begin
        seed = xs(seed);
        write_base(seed[44:0]);
      end
      seed = xs(seed); va = seed;
      seed = xs(seed); fl = int'(seed[1:0]);
      p1 = mk_pte(seed[63:32], fl != 1, seed[30:0]);
      seed = xs(seed);
      p2 = mk_pte(seed[63:32], fl != 2, seed[30:0]);
      seed = xs(seed);
      p3 = mk_pte(seed[63:32], fl != 3, seed[30:0]);
      run_walk(va, p1, p2, p3, 1 + (i % 5), (i % 3) == 0, 0, '0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule